// File: doc/BRIEF.md
# Deflection Torus Switch with Segment Isolation

This block is one router of a unidirectional two-dimensional torus that uses bufferless deflection routing. Packets enter from the West and North links and from the local processing element. They leave on the East link or on the South link. The South link also serves as the local exit: a packet whose destination matches this node is flagged on the South output. Routing is dimension-ordered. A packet travels along X first. It turns South once its X coordinate matches this column, and after that it never leaves the Y ring. A packet that cannot take the output it prefers is deflected onward along the dimension it arrived on. Nothing is stored inside the switch beyond the one output register stage.

Two turn-back inputs, East-wrap and South-wrap, let the switch act as the edge of a sub-network. Each has its own split control. When the East split control is set, the East output carries the East-wrap input in place of the switch's own East traffic. The South split control does the same for the South output. Traffic is then reflected back into its segment instead of crossing the boundary. The split controls are expected to come from static configuration bits.

Top module: `dts_switch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with no input valid, `e_vld`, `s_vld` and `s_here` are 0.
- R2: With `esplit` = 0, a valid West packet whose X field differs from parameter `MY_X` appears on the East output one cycle later, with its X, Y and payload unchanged.
- R3: A valid West packet whose X equals `MY_X` leaves South when the South output is free. It is deflected East when a North packet holds South or `ssplit` = 1.
- R4: With `ssplit` = 0, a valid North packet always leaves on the South output one cycle later and never appears on East. North has the highest priority for South.
- R5: `s_here` is 1 exactly when the registered South packet is valid and its X equals `MY_X` and its Y equals `MY_Y`.
- R6: A local packet asks for South when its X equals `MY_X` and for East otherwise. `pe_ack` is 1 in the same cycle only when that output is not taken by a higher-priority packet or by a split. An acknowledged packet appears on that output one cycle later.
- R7: With `esplit` = 1, the East output one cycle later carries the East-wrap input, valid bit included. West and local packets bound East are not forwarded, and no local packet bound East is acknowledged.
- R8: With `ssplit` = 1, the South output one cycle later carries the South-wrap input, valid bit included. North packets are not forwarded.
- R9: When no selected source is valid, both outputs are invalid one cycle later. An invalid input never produces a valid output.
- R10: Every forwarded packet keeps its payload bit for bit, and the output register adds exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esplit | input | 1 | East output takes the East-wrap input |
| ssplit | input | 1 | South output takes the South-wrap input |
| w_vld | input | 1 | West packet valid |
| w_x | input | X_W | West packet destination column |
| w_y | input | Y_W | West packet destination row |
| w_data | input | DATA_W | West packet payload |
| n_vld | input | 1 | North packet valid |
| n_x | input | X_W | North packet destination column |
| n_y | input | Y_W | North packet destination row |
| n_data | input | DATA_W | North packet payload |
| pe_vld | input | 1 | Local injection valid |
| pe_x | input | X_W | Local packet destination column |
| pe_y | input | Y_W | Local packet destination row |
| pe_data | input | DATA_W | Local packet payload |
| pe_ack | output | 1 | Local packet accepted this cycle |
| ewrap_vld | input | 1 | East-wrap packet valid |
| ewrap_x | input | X_W | East-wrap destination column |
| ewrap_y | input | Y_W | East-wrap destination row |
| ewrap_data | input | DATA_W | East-wrap payload |
| swrap_vld | input | 1 | South-wrap packet valid |
| swrap_x | input | X_W | South-wrap destination column |
| swrap_y | input | Y_W | South-wrap destination row |
| swrap_data | input | DATA_W | South-wrap payload |
| e_vld | output | 1 | East packet valid |
| e_x | output | X_W | East packet destination column |
| e_y | output | Y_W | East packet destination row |
| e_data | output | DATA_W | East packet payload |
| s_vld | output | 1 | South packet valid |
| s_x | output | X_W | South packet destination column |
| s_y | output | Y_W | South packet destination row |
| s_data | output | DATA_W | South packet payload |
| s_here | output | 1 | South packet is addressed to this node |

## Verification
The hardest situation to reach is a three-way contest. A North packet holds South, a West packet wants to turn South, and a local packet wants East, so the West packet is deflected and takes East ahead of the local packet. The same contest must then be seen with one or both split controls set. The stimulus covers every combination of the five valid bits and the two split controls. Each combination is crossed with column-match and node-match choices for the West, local and North packets. Every priority collision and every split case therefore occurs many times, with fresh payloads each cycle.

// File: rtl/dts_pkg.sv
package dts_pkg;
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_WEST  = 3'd1,
        SEL_NORTH = 3'd2,
        SEL_LOCAL = 3'd3,
        SEL_WRAP  = 3'd4
    } src_sel_e;
endpackage

// File: rtl/dts_col_match.sv
module dts_col_match #(
    parameter int X_W  = 3,
    parameter int MY_X = 0
) (
    input  logic           vld,
    input  logic [X_W-1:0] x,
    output logic           hit
);
    localparam logic [X_W-1:0] COL = X_W'(MY_X);

    always_comb begin
        hit = vld && (x == COL);
    end
endmodule

// File: rtl/dts_out_mux.sv
module dts_out_mux #(
    parameter int FLIT_W = 8
) (
    input  dts_pkg::src_sel_e  sel,
    input  logic [FLIT_W-1:0]  west,
    input  logic [FLIT_W-1:0]  north,
    input  logic [FLIT_W-1:0]  local_in,
    input  logic [FLIT_W-1:0]  wrap,
    output logic [FLIT_W-1:0]  flit
);
    always_comb begin
        case (sel)
            dts_pkg::SEL_WEST:  flit = west;
            dts_pkg::SEL_NORTH: flit = north;
            dts_pkg::SEL_LOCAL: flit = local_in;
            dts_pkg::SEL_WRAP:  flit = wrap;
            default:            flit = '0;
        endcase
    end
endmodule

// File: rtl/dts_switch.sv
module dts_switch #(
    parameter int DATA_W = 256,
    parameter int X_W    = 3,
    parameter int Y_W    = 3,
    parameter int MY_X   = 2,
    parameter int MY_Y   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              esplit,
    input  logic              ssplit,
    input  logic              w_vld,
    input  logic [X_W-1:0]    w_x,
    input  logic [Y_W-1:0]    w_y,
    input  logic [DATA_W-1:0] w_data,
    input  logic              n_vld,
    input  logic [X_W-1:0]    n_x,
    input  logic [Y_W-1:0]    n_y,
    input  logic [DATA_W-1:0] n_data,
    input  logic              pe_vld,
    input  logic [X_W-1:0]    pe_x,
    input  logic [Y_W-1:0]    pe_y,
    input  logic [DATA_W-1:0] pe_data,
    output logic              pe_ack,
    input  logic              ewrap_vld,
    input  logic [X_W-1:0]    ewrap_x,
    input  logic [Y_W-1:0]    ewrap_y,
    input  logic [DATA_W-1:0] ewrap_data,
    input  logic              swrap_vld,
    input  logic [X_W-1:0]    swrap_x,
    input  logic [Y_W-1:0]    swrap_y,
    input  logic [DATA_W-1:0] swrap_data,
    output logic              e_vld,
    output logic [X_W-1:0]    e_x,
    output logic [Y_W-1:0]    e_y,
    output logic [DATA_W-1:0] e_data,
    output logic              s_vld,
    output logic [X_W-1:0]    s_x,
    output logic [Y_W-1:0]    s_y,
    output logic [DATA_W-1:0] s_data,
    output logic              s_here
);
    import dts_pkg::*;

    localparam int FLIT_W = 1 + X_W + Y_W + DATA_W;
    localparam int N_DEC  = 4;
    localparam logic [Y_W-1:0] ROW = Y_W'(MY_Y);

    typedef struct packed {
        logic [FLIT_W-1:0] east;
        logic [FLIT_W-1:0] south;
        logic              here;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [FLIT_W-1:0] w_flit, n_flit, pe_flit, ew_flit, sw_flit;
    logic [FLIT_W-1:0] e_next, s_next;
    logic [N_DEC-1:0]  dec_vld;
    logic [X_W-1:0]    dec_x [N_DEC];
    logic [N_DEC-1:0]  col_hit;
    src_sel_e          e_sel, s_sel;

    assign w_flit  = {w_vld, w_x, w_y, w_data};
    assign n_flit  = {n_vld, n_x, n_y, n_data};
    assign pe_flit = {pe_vld, pe_x, pe_y, pe_data};
    assign ew_flit = {ewrap_vld, ewrap_x, ewrap_y, ewrap_data};
    assign sw_flit = {swrap_vld, swrap_x, swrap_y, swrap_data};

    // decoder inputs: 0 west, 1 north, 2 local, 3 chosen south packet
    assign dec_vld  = {s_next[FLIT_W-1], pe_vld, n_vld, w_vld};
    assign dec_x[0] = w_x;
    assign dec_x[1] = n_x;
    assign dec_x[2] = pe_x;
    assign dec_x[3] = s_next[FLIT_W-2 -: X_W];

    generate
        for (genvar i = 0; i < N_DEC; i++) begin : g_dec
            dts_col_match #(.X_W(X_W), .MY_X(MY_X)) u_match (
                .vld (dec_vld[i]),
                .x   (dec_x[i]),
                .hit (col_hit[i])
            );
        end
    endgenerate

    // South: split wrap, then North, then West turning, then local
    always_comb begin
        if (ssplit)           s_sel = SEL_WRAP;
        else if (n_vld)       s_sel = SEL_NORTH;
        else if (col_hit[0])  s_sel = SEL_WEST;
        else if (col_hit[2])  s_sel = SEL_LOCAL;
        else                  s_sel = SEL_NONE;
    end

    // East: split wrap, then West (straight or deflected), then local
    always_comb begin
        if (esplit)                          e_sel = SEL_WRAP;
        else if (w_vld && s_sel != SEL_WEST) e_sel = SEL_WEST;
        else if (pe_vld && !col_hit[2])      e_sel = SEL_LOCAL;
        else                                 e_sel = SEL_NONE;
    end

    dts_out_mux #(.FLIT_W(FLIT_W)) u_mux_e (
        .sel(e_sel), .west(w_flit), .north(n_flit), .local_in(pe_flit),
        .wrap(ew_flit), .flit(e_next)
    );

    dts_out_mux #(.FLIT_W(FLIT_W)) u_mux_s (
        .sel(s_sel), .west(w_flit), .north(n_flit), .local_in(pe_flit),
        .wrap(sw_flit), .flit(s_next)
    );

    always_comb begin
        pe_ack     = (e_sel == SEL_LOCAL) || (s_sel == SEL_LOCAL);
        st_d       = st_q;
        st_d.east  = e_next;
        st_d.south = s_next;
        st_d.here  = col_hit[3] && (s_next[DATA_W +: Y_W] == ROW);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign {e_vld, e_x, e_y, e_data} = st_q.east;
    assign {s_vld, s_x, s_y, s_data} = st_q.south;
    assign s_here                    = st_q.here;
endmodule

// File: rtl/dts_switch_chk.sv
module dts_switch_chk #(
    parameter int DATA_W = 256,
    parameter int X_W    = 3,
    parameter int Y_W    = 3,
    parameter int MY_X   = 2,
    parameter int MY_Y   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              esplit,
    input logic              ssplit,
    input logic              w_vld,
    input logic [X_W-1:0]    w_x,
    input logic [DATA_W-1:0] w_data,
    input logic              n_vld,
    input logic [DATA_W-1:0] n_data,
    input logic              pe_vld,
    input logic              pe_ack,
    input logic              ewrap_vld,
    input logic [DATA_W-1:0] ewrap_data,
    input logic              swrap_vld,
    input logic              e_vld,
    input logic [DATA_W-1:0] e_data,
    input logic              s_vld,
    input logic [X_W-1:0]    s_x,
    input logic [Y_W-1:0]    s_y,
    input logic [DATA_W-1:0] s_data,
    input logic              s_here
);
    localparam logic [X_W-1:0] COL = X_W'(MY_X);
    localparam logic [Y_W-1:0] ROW = Y_W'(MY_Y);

    p_west_east_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (w_vld && !esplit && w_x != COL) |=> (e_vld && e_data == $past(w_data)));

    p_north_south_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (n_vld && !ssplit) |=> (s_vld && s_data == $past(n_data)));

    p_here_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_here |-> (s_vld && s_x == COL && s_y == ROW));

    p_ack_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pe_ack |-> pe_vld);

    p_east_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        esplit |=> (e_vld == $past(ewrap_vld) && (!e_vld || e_data == $past(ewrap_data))));

    p_south_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ssplit |=> (s_vld == $past(swrap_vld)));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_vld || n_vld || pe_vld || (esplit && ewrap_vld) || (ssplit && swrap_vld))
        |=> (!e_vld && !s_vld));
endmodule

bind dts_switch dts_switch_chk #(
    .DATA_W(DATA_W), .X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (.*);

// File: tb/dts_switch_test.sv
module dts_switch_test;
    localparam int DW = 256;
    localparam int XW = 3;
    localparam int YW = 3;
    localparam int HX = 2;
    localparam int HY = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic esplit = 0, ssplit = 0;
    logic w_vld = 0, n_vld = 0, pe_vld = 0, ewrap_vld = 0, swrap_vld = 0;
    logic [XW-1:0] w_x = '0, n_x = '0, pe_x = '0, ewrap_x = '0, swrap_x = '0;
    logic [YW-1:0] w_y = '0, n_y = '0, pe_y = '0, ewrap_y = '0, swrap_y = '0;
    logic [DW-1:0] w_data = '0, n_data = '0, pe_data = '0, ewrap_data = '0, swrap_data = '0;
    logic pe_ack, e_vld, s_vld, s_here;
    logic [XW-1:0] e_x, s_x;
    logic [YW-1:0] e_y, s_y;
    logic [DW-1:0] e_data, s_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dts_switch #(.DATA_W(DW), .X_W(XW), .Y_W(YW), .MY_X(HX), .MY_Y(HY)) uut (.*);

    task automatic chk(input string req, input string what, input logic [DW+XW+YW:0] act,
                       input logic [DW+XW+YW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rnd_data();
        logic [DW-1:0] r;
        for (int k = 0; k < DW / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    // reference: source codes 0 none, 1 west, 2 north, 3 local, 4 wrap
    int exp_e_src, exp_s_src;
    bit exp_ack;
    logic [DW+XW+YW:0] exp_e, exp_s;
    bit exp_here;

    task automatic model();
        int wdest, pdest;
        // wanted direction: 0 none, 1 east, 2 south
        wdest = !w_vld ? 0 : (int'(w_x) == HX ? 2 : 1);
        pdest = !pe_vld ? 0 : (int'(pe_x) == HX ? 2 : 1);
        exp_s_src = 0;
        if (ssplit) exp_s_src = 4;
        else if (n_vld) exp_s_src = 2;
        else if (wdest == 2) exp_s_src = 1;
        else if (pdest == 2) exp_s_src = 3;
        exp_e_src = 0;
        if (esplit) exp_e_src = 4;
        else if (wdest != 0 && exp_s_src != 1) exp_e_src = 1;
        else if (pdest == 1) exp_e_src = 3;
        exp_ack = (exp_e_src == 3) || (exp_s_src == 3);
        exp_e = pick(exp_e_src, 1);
        exp_s = pick(exp_s_src, 0);
        exp_here = exp_s[DW+XW+YW] && (int'(exp_s[DW+YW +: XW]) == HX) && (int'(exp_s[DW +: YW]) == HY);
    endtask

    function automatic logic [DW+XW+YW:0] pick(input int src, input bit east);
        case (src)
            1: return {w_vld, w_x, w_y, w_data};
            2: return {n_vld, n_x, n_y, n_data};
            3: return {pe_vld, pe_x, pe_y, pe_data};
            4: return east ? {ewrap_vld, ewrap_x, ewrap_y, ewrap_data}
                           : {swrap_vld, swrap_x, swrap_y, swrap_data};
            default: return '0;
        endcase
    endfunction

    function automatic string e_tag(input int src);
        if (esplit) return "R7";
        if (src == 0) return "R9";
        if (src == 1 && int'(w_x) == HX) return "R3";
        if (src == 1) return "R2";
        return "R6";
    endfunction

    function automatic string s_tag(input int src);
        if (ssplit) return "R8";
        if (src == 0) return "R9";
        if (src == 2) return "R4";
        if (src == 1) return "R3";
        return "R6";
    endfunction

    initial begin : main
        string et, st;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "e_vld in reset", {'0, e_vld}, '0);
        chk("R1", "s_vld in reset", {'0, s_vld}, '0);
        chk("R1", "s_here in reset", {'0, s_here}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "outputs idle after reset", {'0, e_vld, s_vld, s_here}, '0);

        for (int c = 0; c < 128 * 8; c++) begin
            @(negedge clk);
            {w_vld, n_vld, pe_vld, ewrap_vld, swrap_vld, esplit, ssplit} = 7'(c % 128);
            w_x  = (c / 128) % 2 == 1 ? XW'(HX) : XW'(HX + 1);
            pe_x = (c / 256) % 2 == 1 ? XW'(HX) : XW'(HX + 3);
            n_x  = (c / 512) % 2 == 1 ? XW'(HX) : XW'($urandom_range(0, 7));
            n_y  = (c / 512) % 2 == 1 ? YW'(HY) : YW'($urandom_range(0, 7));
            w_y  = YW'($urandom_range(0, 7));
            pe_y = (c % 3 == 0) ? YW'(HY) : YW'($urandom_range(0, 7));
            ewrap_x = XW'($urandom_range(0, 7)); ewrap_y = YW'($urandom_range(0, 7));
            swrap_x = (c % 5 == 0) ? XW'(HX) : XW'($urandom_range(0, 7));
            swrap_y = (c % 5 == 0) ? YW'(HY) : YW'($urandom_range(0, 7));
            w_data = rnd_data(); n_data = rnd_data(); pe_data = rnd_data();
            ewrap_data = rnd_data(); swrap_data = rnd_data();
            model();
            et = e_tag(exp_e_src);
            st = s_tag(exp_s_src);
            #1;
            chk("R6", "pe_ack", {'0, pe_ack}, {'0, exp_ack});
            @(posedge clk);
            #1;
            // R10: whole flit including payload, one cycle after the inputs
            chk(et, "east flit", {e_vld, e_x, e_y, e_data}, exp_e);
            chk(st, "south flit", {s_vld, s_x, s_y, s_data}, exp_s);
            chk("R5", "s_here", {'0, s_here}, {'0, exp_here});
        end

        @(negedge clk);
        {w_vld, n_vld, pe_vld, ewrap_vld, swrap_vld, esplit, ssplit} = '0;
        @(posedge clk);
        #1;
        chk("R9", "idle after traffic", {'0, e_vld, s_vld}, '0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(10 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule